// File: doc/BRIEF.md
# Pointer Masking Address Transform

This unit sits in the load/store path of a 64-bit core. Each effective address passes through it before address translation. Software may keep tag bits in the top of a pointer. The unit removes those tag bits by overwriting the top bits of the address with copies of the highest bit it keeps, or with zeros. The number of tag bits comes from a 2-bit masking mode. There are two mode fields: one for ordinary accesses and one for accesses flagged as virtual (guest) accesses. The access flag picks which field applies.

The kind of fill depends on the access and on the state of translation. An ordinary access gets a sign fill while translation is on, and a zero fill otherwise. A virtual access always gets a zero fill. When the core runs with 32-bit registers, the address passes through untouched. By default the unit is purely combinational. A parameter can add one register stage at the output, with no handshake.

Top module: `pm_addr_adjust`

## Requirements
- R1: When `xlen_mode` is anything other than 2 (2 means 64-bit, 1 means 32-bit), `addr_out` equals `addr_in`, whatever the mode fields and flags hold.
- R2: The mode that applies is `pm_mode_virt` when `virt_access` is 1, and `pm_mode` when `virt_access` is 0.
- R3: If the mode that applies is 2'b00 (off) or 2'b01 (reserved), `addr_out` equals `addr_in`.
- R4: Mode 2'b10 replaces the top 7 address bits, and mode 2'b11 replaces the top 16 address bits.
- R5: The replaced bits are copies of bit 63-N of `addr_in` (N is the tag length) only when `virt_access` is 0 and `xlat_on` is 1. In every other masked case they are zeros.
- R6: Address bits below the replaced field always equal the same bits of `addr_in`.
- R7: With `REGISTERED`=1, `addr_out` shows the result for the inputs sampled at the previous rising edge of `clk`. It reads zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Used by the output register and by the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | AW (64) | Effective address |
| virt_access | input | 1 | 1 = virtual (guest) access |
| xlen_mode | input | 2 | 1 = 32-bit, 2 = 64-bit |
| pm_mode | input | 2 | Masking mode for ordinary accesses |
| pm_mode_virt | input | 2 | Masking mode for virtual accesses |
| xlat_on | input | 1 | Address translation currently enabled |
| addr_out | output | AW (64) | Adjusted address |

## Verification
The assertions assume that the inputs are settled at each rising edge and that every input holds a known value after reset. The bench meets this by changing inputs only on falling edges and by never leaving a field undriven. Each check on the combinational result looks at a single cycle, so any mix of modes and flags is legal stimulus. The bench sweeps every combination of the 2-bit fields and the flags over a fixed set of addresses. This set has the kept top bit set and clear for both tag lengths, the all-ones address, and the lone top bit. Three random addresses complete the set.

// File: rtl/pm_addr_adjust.sv
module pm_addr_adjust #(
  parameter int AW        = 64,
  parameter int SHORT_TAG = 7,
  parameter int LONG_TAG  = 16,
  parameter bit REGISTERED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          virt_access,
  input  logic [1:0]    xlen_mode,
  input  logic [1:0]    pm_mode,
  input  logic [1:0]    pm_mode_virt,
  input  logic          xlat_on,
  output logic [AW-1:0] addr_out
);
  localparam int SW = $clog2(AW) + 1;
  localparam logic [1:0] WIDE = 2'd2;

  logic [1:0]    mode_sel;
  logic          active, sext;
  logic [SW-1:0] shamt;
  logic [AW-1:0] up, adj;

  assign mode_sel = virt_access ? pm_mode_virt : pm_mode;
  assign active   = (xlen_mode == WIDE) && mode_sel[1];
  assign sext     = !virt_access && xlat_on;
  assign shamt    = !active ? '0 : mode_sel[0] ? SW'(LONG_TAG) : SW'(SHORT_TAG);
  assign up       = addr_in << shamt;
  assign adj      = sext ? AW'($signed(up) >>> shamt) : (up >> shamt);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) addr_out <= '0;
        else        addr_out <= adj;

      assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> addr_out == $past(adj));
    end else begin : g_comb
      assign addr_out = adj;
    end
  endgenerate

  assert_narrow_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xlen_mode != WIDE |-> adj == addr_in);

  assert_off_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen_mode == WIDE && !(virt_access ? pm_mode_virt[1] : pm_mode[1])) |-> adj == addr_in);

  assert_long_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen_mode == WIDE && (virt_access ? pm_mode_virt : pm_mode) == 2'b11)
      |-> ($countones(adj[AW-1 -: LONG_TAG]) == 0 || $countones(adj[AW-1 -: LONG_TAG]) == LONG_TAG));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen_mode == WIDE && virt_access && pm_mode_virt[1]) |-> adj[AW-1 -: SHORT_TAG] == '0);

  assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen_mode == WIDE && !virt_access && xlat_on && pm_mode[1])
      |-> adj[AW-1] == addr_in[AW-1-(pm_mode[0] ? LONG_TAG : SHORT_TAG)]);

  assert_low_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adj[AW-1-LONG_TAG:0] == addr_in[AW-1-LONG_TAG:0]);
endmodule

// File: tb/pm_addr_adjust_test.sv
module pm_addr_adjust_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] addr_in = '0;
  logic        virt_access = 1'b0, xlat_on = 1'b0;
  logic [1:0]  xlen_mode = 2'd2, pm_mode = '0, pm_mode_virt = '0;
  logic [63:0] out_c, out_p;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pm_addr_adjust uut (.clk, .rst_n, .addr_in, .virt_access, .xlen_mode,
    .pm_mode, .pm_mode_virt, .xlat_on, .addr_out(out_c));
  pm_addr_adjust #(.REGISTERED(1'b1)) uut_p (.clk, .rst_n, .addr_in, .virt_access,
    .xlen_mode, .pm_mode, .pm_mode_virt, .xlat_on, .addr_out(out_p));

  function automatic logic [63:0] expect_of(logic [63:0] a, logic [1:0] xm, logic v,
      logic [1:0] m, logic [1:0] mv, logic xl, output string tag);
    logic [1:0] ms = v ? mv : m;
    int n;
    logic [63:0] top, fill;
    if (xm != 2'd2) begin tag = "R1"; return a; end
    if (ms[1] == 1'b0) begin tag = "R3"; return a; end
    n = ms[0] ? 16 : 7;
    top = ~(64'hFFFF_FFFF_FFFF_FFFF >> n);
    fill = (!v && xl && a[63-n]) ? top : 64'd0;
    tag = (!v && xl) ? "R5" : (v ? "R2" : "R4");
    return (a & ~top) | fill;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pick(int i);
    case (i)
      0: return 64'd0;
      1: return '1;
      2: return 64'h0100_0000_0000_0000;
      3: return 64'h0000_8000_0000_0000;
      4: return ~64'h0100_0000_0000_0000;
      5: return ~64'h0000_8000_0000_0000;
      6: return 64'h8000_0000_0000_0000;
      7: return 64'h1234_5678_9ABC_DEF0;
      8: return 64'hFEDC_BA98_7654_3210;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [63:0] exp;
    repeat (2) @(negedge clk);
    check("R7 reset", out_p, 64'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 12; a++) begin
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        addr_in = pick(a);
        xlen_mode = 2'(k[1:0]);
        pm_mode = 2'(k[3:2]);
        pm_mode_virt = 2'(k[5:4]);
        virt_access = k[6];
        xlat_on = k[7];
        exp = expect_of(addr_in, xlen_mode, virt_access, pm_mode, pm_mode_virt, xlat_on, tag);
        @(posedge clk); #1;
        check(tag, out_c, exp);
        check("R7 pipe", out_p, exp);
        check("R6 low bits", out_c[47:0], addr_in[47:0]);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule